// File: doc/BRIEF.md
# T1 Terminal Frame Position Hunter

This block finds the framing bit in a serial T1 stream of 193-bit frames. Every bit position of the frame is a candidate. For each candidate the block remembers the last few samples taken at that position in successive frames. A candidate is struck off the moment a fresh sample breaks the expected alternation. While a hunt runs, the previously chosen position stays on the output and a busy flag is raised. When the hunt settles, the new position is published together with a one-cycle lock pulse.

A hunt starts on a request pulse and always begins its scan at the position just after the current alignment, so that a repeated request walks past a position that only mimics the framing pattern. The hunt ends in one of three ways, each judged at the end of a scan frame:

- Exactly one survivor from the tenth frame on locks to that survivor.
- No survivor from the tenth frame on starts the hunt over.
- Several survivors at the twenty-fourth frame lock to the first survivor that arrives next in scan order.

A mode input selects which alternation rule is applied.

Top module: `t1_frame_hunter`

## Requirements
- R1: After reset, `align_pos` is 0, and `lock` and `searching` are both low.
- R2: A `start_req` pulse raises `searching` on the following cycle. The hunt's scan frames then begin at position (`align_pos`+1) mod 193, and each scan frame covers 193 consecutive bit positions from there.
- R3: With `alt_mode`=0, a candidate that already holds two samples in the current hunt is removed when its new sample equals the sample taken two frames earlier. A pattern 1,1,0,0 repeating therefore survives.
- R4: With `alt_mode`=1, a candidate that already holds one sample is removed when its new sample equals the previous sample. A pattern 1,0 repeating therefore survives.
- R5: If exactly one candidate is alive at the end of scan frame 10 or any later scan frame, `align_pos` takes that position and `lock` is high for exactly one cycle. At the same cycle, `searching` falls.
- R6: If no candidate is alive at the end of scan frame 10 or any later scan frame, the hunt restarts with every candidate alive. No lock is reported and `searching` stays high.
- R7: If two or more candidates are alive at the end of scan frame 24, the block locks to the first candidate that passes its check after that point in scan order.
- R8: While `searching` is high, `align_pos` keeps its previous value until a lock occurs.
- R9: Samples and position advance only on cycles where `bit_en` is high.
- R10: A `start_req` during a hunt discards the hunt and begins a new one under R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Strobe marking a valid line bit on `din` |
| din | input | 1 | Serial line data |
| start_req | input | 1 | One-cycle request to start or restart a hunt |
| alt_mode | input | 1 | Alternation rule: 0 = inverse of two frames back, 1 = inverse of previous frame |
| align_pos | output | 8 | Current frame bit position taken as the framing bit |
| lock | output | 1 | One-cycle pulse when a new alignment is taken |
| searching | output | 1 | High while a hunt is in progress |

## Verification
The hardest outcome to reach is the timeout path. It needs two or more positions to carry a valid alternation for 24 full frames while every other position dies. It also needs a scan start chosen so that the expected winner is not the lower index. The stimulus places the valid pattern at positions 30 and 120 and fills all other positions with zeros. It first locks the block at 70 so the next hunt scans from 71, which makes 120 the required answer. The restart path is reached by sending all-zero data for more than two restart periods before a pattern appears. A reference model in the bench follows every clock and checks the timing of each lock.

// File: rtl/t1_frame_hunter.sv
module t1_frame_hunter #(
  parameter int N              = 193,
  parameter int LOCK_FRAMES    = 10,
  parameter int TIMEOUT_FRAMES = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_en,
  input  logic                 din,
  input  logic                 start_req,
  input  logic                 alt_mode,
  output logic [$clog2(N)-1:0] align_pos,
  output logic                 lock,
  output logic                 searching
);
  localparam int PW = $clog2(N);
  localparam int CW = $clog2(N + 1);
  localparam int FW = $clog2(TIMEOUT_FRAMES + 1);
  localparam logic [PW-1:0] LASTP = PW'(N - 1);
  localparam logic [FW-1:0] LOCKF = FW'(LOCK_FRAMES);
  localparam logic [FW-1:0] TOUTF = FW'(TIMEOUT_FRAMES);
  localparam logic [CW-1:0] ALLC  = CW'(N);

  typedef enum logic [1:0] {IDLE, WAIT, SCAN, PICK} st_t;
  st_t st;

  logic [PW-1:0] raw, start_pos, surv;
  logic [N-1:0]  alive;
  logic [2:0]    hist [N];
  logic [FW-1:0] fcnt;
  logic [CW-1:0] live;

  wire [PW-1:0] end_pos   = (start_pos == '0) ? LASTP : start_pos - PW'(1);
  wire [PW-1:0] nxt_start = (align_pos == LASTP) ? '0 : align_pos + PW'(1);
  wire go = bit_en && (st == SCAN || st == PICK || (st == WAIT && raw == start_pos));

  wire [2:0]    h        = hist[raw];
  wire          primed   = alt_mode ? (fcnt != '0) : (fcnt > FW'(1));
  wire          clash    = primed && (alt_mode ? (din == h[0]) : (din == h[1]));
  wire          keep     = alive[raw] && !clash;
  wire [CW-1:0] live_n   = live - CW'(alive[raw] && clash);
  wire          last     = (raw == end_pos);
  wire [FW-1:0] fc_n     = (fcnt == TOUTF) ? fcnt : fcnt + FW'(1);
  wire          judge    = last && (fc_n >= LOCKF);
  wire [PW-1:0] surv_n   = keep ? raw : surv;
  wire          pick_now = (st == PICK) && keep;
  wire          lock_now = go && (pick_now || (judge && live_n == CW'(1)));
  wire [PW-1:0] lock_at  = pick_now ? raw : surv_n;
  wire          restart  = go && judge && (live_n == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)
      raw <= '0;
    else if (bit_en)
      raw <= (raw == LASTP) ? '0 : raw + PW'(1);
  end

  always_ff @(posedge clk) begin
    if (go)
      hist[raw] <= {h[1:0], din};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= IDLE;
      align_pos <= '0;
      lock      <= 1'b0;
      searching <= 1'b0;
      start_pos <= '0;
      surv      <= '0;
      alive     <= '1;
      fcnt      <= '0;
      live      <= ALLC;
    end else if (start_req) begin
      st        <= WAIT;
      start_pos <= nxt_start;
      alive     <= '1;
      fcnt      <= '0;
      live      <= ALLC;
      lock      <= 1'b0;
      searching <= 1'b1;
    end else begin
      lock <= 1'b0;
      if (go) begin
        alive[raw] <= keep;
        live       <= live_n;
        surv       <= surv_n;
        if (lock_now) begin
          st        <= IDLE;
          align_pos <= lock_at;
          lock      <= 1'b1;
          searching <= 1'b0;
        end else if (restart) begin
          st    <= SCAN;
          alive <= '1;
          live  <= ALLC;
          fcnt  <= '0;
        end else begin
          if (st == WAIT) st <= SCAN;
          if (last) begin
            fcnt <= fc_n;
            if (fc_n == TOUTF) st <= PICK;
          end
        end
      end
    end
  end
endmodule

module t1_frame_hunter_chk #(
  parameter int N = 193
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start_req,
  input logic [$clog2(N)-1:0] align_pos,
  input logic                 lock,
  input logic                 searching
);
  AST_LOCK_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> !lock); // R5
  AST_LOCK_CLEARS_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> !searching); // R5
  AST_LOCK_FOLLOWS_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> $past(searching)); // R5
  AST_ALIGN_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    align_pos <= ($clog2(N))'(N - 1)); // R5
  AST_START_RAISES_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> (searching && !lock)); // R2
  AST_ALIGN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    searching |=> (lock || $stable(align_pos))); // R8
endmodule

bind t1_frame_hunter t1_frame_hunter_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_req(start_req),
  .align_pos(align_pos), .lock(lock), .searching(searching)
);

// File: tb/tb_t1_frame_hunter.sv
module tb_t1_frame_hunter;
  localparam int NB = 193;

  logic clk = 1'b0;
  logic rst_n, bit_en, din, start_req, alt_mode;
  logic [7:0] align_pos;
  logic lock, searching;

  always #2 clk = ~clk;

  t1_frame_hunter dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .din(din), .start_req(start_req),
    .alt_mode(alt_mode), .align_pos(align_pos), .lock(lock), .searching(searching)
  );

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // stimulus: per-position patterns, kind 0 = 1,1,0,0 ; kind 1 = 1,0
  int pa = -1, pb = -1, ka = 0, kb = 0;
  int cyc = 0, b_raw = 0, b_frame = 0;
  logic en_run = 1'b0;

  function automatic logic pat(input int p, input int f);
    if (p == pa) return ka != 0 ? (f % 2 == 0) : ((f % 4) < 2);
    if (p == pb) return kb != 0 ? (f % 2 == 0) : ((f % 4) < 2);
    return 1'b0;
  endfunction

  initial begin bit_en = 1'b0; din = 1'b0; end
  always @(negedge clk) begin
    if (bit_en) begin
      if (b_raw == NB - 1) begin b_raw = 0; b_frame++; end
      else b_raw++;
    end
    cyc++;
    bit_en = en_run && (cyc % 3 != 2);   // R9: strobe gaps
    din = pat(b_raw, b_frame);
  end

  // behavioural reference model
  int m_raw, m_st, m_start, m_fc, m_align;
  bit m_lock, m_srch;
  bit m_alive [NB];
  int m_p1 [NB];
  int m_p2 [NB];

  function automatic int count_alive();
    int n = 0;
    for (int i = 0; i < NB; i++) if (m_alive[i]) n++;
    return n;
  endfunction

  function automatic int first_alive();
    for (int i = 0; i < NB; i++) if (m_alive[i]) return i;
    return -1;
  endfunction

  task automatic m_take(input int p);
    m_align = p; m_lock = 1; m_srch = 0; m_st = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_raw = 0; m_st = 0; m_start = 0; m_fc = 0; m_align = 0; m_lock = 0; m_srch = 0;
    end else begin
      m_lock = 0;
      if (start_req) begin
        m_st = 1; m_start = (m_align + 1) % NB; m_fc = 0; m_srch = 1;
        for (int i = 0; i < NB; i++) m_alive[i] = 1;
      end else if (bit_en && (m_st >= 2 || (m_st == 1 && m_raw == m_start))) begin
        int c;
        c = m_raw;
        if (m_st == 1) m_st = 2;
        if (m_alive[c]) begin
          if (alt_mode && m_fc >= 1 && din == m_p1[c]) m_alive[c] = 0;
          if (!alt_mode && m_fc >= 2 && din == m_p2[c]) m_alive[c] = 0;
        end
        m_p2[c] = m_p1[c];
        m_p1[c] = din;
        if (m_st == 3 && m_alive[c]) m_take(c);
        else if (c == (m_start + NB - 1) % NB) begin
          if (m_fc < 24) m_fc++;
          if (m_fc >= 10) begin
            if (count_alive() == 1) m_take(first_alive());
            else if (count_alive() == 0) begin
              m_fc = 0;
              for (int i = 0; i < NB; i++) m_alive[i] = 1;
            end else if (m_fc == 24) m_st = 3;
          end
        end
      end
      if (bit_en) m_raw = (m_raw + 1) % NB;
    end
  end

  bit cmp_on = 0;
  always @(negedge clk) begin
    if (cmp_on) begin
      chk(lock == m_lock, "R5 lock vs model", lock, m_lock);
      chk(searching == m_srch, "R2 searching vs model", searching, m_srch);
      chk(int'(align_pos) == m_align, "R8 align_pos vs model", align_pos, m_align);
    end
  end

  task automatic pulse_start();
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
  endtask

  task automatic wait_lock(input int limit, output bit got, output int took);
    got = 0; took = 0;
    while (took < limit && !got) begin
      @(negedge clk); took++;
      if (lock) got = 1;
    end
  endtask

  bit done = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit got;
    int took;
    rst_n = 1'b0; start_req = 1'b0; alt_mode = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(align_pos == 0, "R1 align_pos after reset", align_pos, 0);
    chk(lock == 0, "R1 lock after reset", lock, 0);
    chk(searching == 0, "R1 searching after reset", searching, 0);
    cmp_on = 1;
    en_run = 1'b1;

    // R3: single valid position at 50, all others zero
    pa = 50; ka = 0;
    pulse_start();
    chk(searching == 1, "R2 searching after start", searching, 1);
    wait_lock(20000, got, took);
    chk(got, "R5 lock for single survivor", got, 1);
    chk(align_pos == 50, "R3 aligned position", align_pos, 50);
    chk(searching == 0, "R5 searching after lock", searching, 0);

    // R6: no valid position, hunt restarts without lock
    pa = -1;
    pulse_start();
    wait_lock(9000, got, took);
    chk(!got, "R6 no lock on empty hunt", got, 0);
    chk(searching == 1, "R6 searching held on empty hunt", searching, 1);
    chk(align_pos == 50, "R8 previous alignment held", align_pos, 50);
    pa = 70;
    wait_lock(20000, got, took);
    chk(got && align_pos == 70, "R6 lock after restart", align_pos, 70);

    // R7: two survivors at 30 and 120, scan starts at 71
    pa = 30; pb = 120; kb = 0;
    pulse_start();
    repeat (3000) @(negedge clk);
    chk(searching == 1 && align_pos == 70, "R8 align held mid hunt", align_pos, 70);
    wait_lock(20000, got, took);
    chk(got, "R7 lock after timeout", got, 1);
    chk(align_pos == 120, "R7 first survivor in scan order (R2 start)", align_pos, 120);

    // R10: restart mid-hunt delays the lock
    pa = 120; pb = -1;
    pulse_start();
    repeat (1500) @(negedge clk);
    pulse_start();
    wait_lock(20000, got, took);
    chk(got && align_pos == 120, "R10 lock after restarted hunt", align_pos, 120);
    chk(took > 2800, "R10 hunt restarted from second request", took, 2801);

    // R4 with R9: alternate rule, strobe held off for a while
    alt_mode = 1'b1;
    pa = 5; ka = 1; pb = 10; kb = 0;
    pulse_start();
    en_run = 1'b0;
    wait_lock(5000, got, took);
    chk(!got && searching == 1, "R9 no progress without strobe", got, 0);
    en_run = 1'b1;
    wait_lock(20000, got, took);
    chk(got, "R4 lock under alternate rule", got, 1);
    chk(align_pos == 5, "R4 alternating position chosen", align_pos, 5);

    repeat (5) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule